// File: doc/BRIEF.md
# Predicated Strided Segment Load Address Generator

This block turns one vectorised load into the ordered list of memory requests it needs. A start pulse captures the operands: base address, element size, a scalar stride, the segment count, the vector length, a predicate word with its enable and invert controls, and the first destination register. The block then issues one request per (element, segment) pair on a valid/ready channel. Each request carries a byte address, a destination register number and an element position. It pulses done once the last request has been taken.

The stride is either the element size or the scalar stride input. When the offset operand is marked as a vector, the access becomes indexed. Each element's offset is then read through a small index read port instead of being derived from the element number. Elements that the predicate rules out produce no requests at all. Nothing is zeroed or written for them. Memory access and register writeback belong to the blocks downstream.

Top module: `vsl_seg_load_agen`

## Requirements
- R1: After reset, req_valid and done are low.
- R2: With const_stride low, the stride S is elem_size. A non-indexed request for element i, segment j (segment count seg_len+1) has address base_addr + (i*(seg_len+1) + j)*S.
- R3: With const_stride high, the stride S is stride_val. The address formula of R2 applies unchanged.
- R4: With offs_vec high, idx_rd_sel shows the element of the pending request. The address is base_addr + idx_rd_data + j*S, where S is selected as in R2/R3.
- R5: Segments form the inner loop and elements the outer loop, in ascending order. req_reg is (rd_base + j) mod 2^REGW and req_elem is i.
- R6: With pred_en high, element i is issued only if pred_mask[i] XOR pred_inv is 1. Elements at or above vl are never issued.
- R7: With pred_en low, every element below vl is issued.
- R8: While req_valid is high and req_ready low, req_valid, req_addr, req_reg and req_elem hold their values into the next cycle.
- R9: done is high for exactly one cycle. That cycle follows the edge that accepts the last request, or follows the start edge if no element is enabled. req_valid is low whenever done is high.
- R10: All address arithmetic wraps modulo 2^AW.
- R11: A start pulse while requests are still pending is ignored. The running sequence continues with its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin (used only when idle) |
| base_addr | input | AW | Scalar base address |
| elem_size | input | AW | Element size in bytes (unit stride) |
| stride_val | input | AW | Scalar stride in bytes |
| const_stride | input | 1 | 1: stride_val is the stride, 0: elem_size is the stride |
| offs_vec | input | 1 | Offset operand is a vector: indexed access |
| idx_rd_sel | output | VLW | Element whose index offset is requested |
| idx_rd_data | input | AW | Index offset for idx_rd_sel (same cycle) |
| seg_len | input | SEGW | Segments per element minus one |
| vl | input | VLW+1 | Vector length, 0..MAXVL |
| pred_en | input | 1 | Predication active for the destination |
| pred_inv | input | 1 | Invert predicate bits |
| pred_mask | input | MAXVL | Predicate bit per element |
| rd_base | input | REGW | First destination register |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Request taken this cycle when valid |
| req_addr | output | AW | Request byte address |
| req_reg | output | REGW | Destination register of the request |
| req_elem | output | VLW | Element position of the request |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the per-cycle properties on every cycle. These are request hold under back-pressure, predicate and length compliance of every issued element, and the step from one segment to the next or from one element to the next. They also cover done following the final accept, and operands staying frozen when start arrives while busy. Exact address values in each of the three offset modes can only be shown by the bench's scenarios. The same holds for wrap at the top of the address space, the full set and order of emitted requests, and a sequence that ends with no request at all. The bench compares every accepted request against a list it computes itself.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  typedef enum logic {
    STRIDE_ELEM  = 1'b0,
    STRIDE_SCALAR = 1'b1
  } stride_sel_e;
endpackage

// File: rtl/vsl_elem_mask.sv
module vsl_elem_mask #(
  parameter int MAXVL = 16,
  localparam int VLW = $clog2(MAXVL)
) (
  input  logic [VLW:0]     vl,
  input  logic             pen,
  input  logic             pinv,
  input  logic [MAXVL-1:0] pmask,
  output logic [MAXVL-1:0] live
);
  for (genvar g = 0; g < MAXVL; g++) begin : g_lane
    logic in_len;
    assign in_len  = ((VLW+1)'(g) < vl);
    assign live[g] = in_len && (!pen || (pmask[g] ^ pinv));
  end
endmodule

// File: rtl/vsl_pred_scan.sv
module vsl_pred_scan #(
  parameter int MAXVL = 16,
  localparam int VLW = $clog2(MAXVL)
) (
  input  logic [MAXVL-1:0] live,
  input  logic [VLW:0]     from,
  output logic             found,
  output logic [VLW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = MAXVL - 1; i >= 0; i--) begin
      if (live[i] && ((VLW+1)'(i) >= from)) begin
        found = 1'b1;
        idx   = VLW'(i);
      end
    end
  end
endmodule

// File: rtl/vsl_addr_calc.sv
module vsl_addr_calc #(
  parameter int AW    = 32,
  parameter int MAXVL = 16,
  parameter int SEGW  = 3,
  localparam int VLW = $clog2(MAXVL)
) (
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [SEGW-1:0] seglen,
  input  logic [VLW-1:0]  elem,
  input  logic [SEGW-1:0] seg,
  input  logic            indexed,
  input  logic [AW-1:0]   idx_off,
  output logic [AW-1:0]   addr
);
  function automatic logic [AW-1:0] group_off(input logic [VLW-1:0] e,
                                              input logic [SEGW-1:0] sl,
                                              input logic [AW-1:0] st);
    logic [AW-1:0] grp;
    grp = AW'(e) * (AW'(sl) + AW'(1));
    return grp * st;
  endfunction

  function automatic logic [AW-1:0] seg_off(input logic [SEGW-1:0] s,
                                            input logic [AW-1:0] st);
    return AW'(s) * st;
  endfunction

  logic [AW-1:0] elem_off;
  assign elem_off = indexed ? idx_off : group_off(elem, seglen, stride);
  assign addr     = base + elem_off + seg_off(seg, stride);
endmodule

// File: rtl/vsl_seg_load_agen.sv
module vsl_seg_load_agen
  import vsl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MAXVL = 16,
  parameter int SEGW  = 3,
  parameter int REGW  = 5,
  localparam int VLW = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [AW-1:0]    elem_size,
  input  logic [AW-1:0]    stride_val,
  input  logic             const_stride,
  input  logic             offs_vec,
  output logic [VLW-1:0]   idx_rd_sel,
  input  logic [AW-1:0]    idx_rd_data,
  input  logic [SEGW-1:0]  seg_len,
  input  logic [VLW:0]     vl,
  input  logic             pred_en,
  input  logic             pred_inv,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [REGW-1:0]  rd_base,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [REGW-1:0]  req_reg,
  output logic [VLW-1:0]   req_elem,
  output logic             done
);
  // captured operands
  logic [AW-1:0]    base_q, stride_q;
  logic             idx_q, pen_q, pinv_q;
  logic [SEGW-1:0]  seglen_q;
  logic [VLW:0]     vl_q;
  logic [MAXVL-1:0] pmask_q;
  logic [REGW-1:0]  rd_q;

  // loop state
  logic             busy_q, done_q;
  logic [VLW-1:0]   elem_q;
  logic [SEGW-1:0]  seg_q;

  stride_sel_e      ssel;
  logic [AW-1:0]    stride_in;
  assign ssel      = stride_sel_e'(const_stride);
  assign stride_in = (ssel == STRIDE_SCALAR) ? stride_val : elem_size;

  // element enables: live operands when idle, captured ones while busy
  logic [VLW:0]     m_vl;
  logic             m_pen, m_pinv;
  logic [MAXVL-1:0] m_mask, live;
  assign m_vl   = busy_q ? vl_q    : vl;
  assign m_pen  = busy_q ? pen_q   : pred_en;
  assign m_pinv = busy_q ? pinv_q  : pred_inv;
  assign m_mask = busy_q ? pmask_q : pred_mask;

  vsl_elem_mask #(.MAXVL(MAXVL)) u_mask (
    .vl(m_vl), .pen(m_pen), .pinv(m_pinv), .pmask(m_mask), .live(live)
  );

  logic [VLW:0]   scan_from;
  logic           nxt_found;
  logic [VLW-1:0] nxt_idx;
  assign scan_from = busy_q ? ({1'b0, elem_q} + (VLW+1)'(1)) : '0;

  vsl_pred_scan #(.MAXVL(MAXVL)) u_scan (
    .live(live), .from(scan_from), .found(nxt_found), .idx(nxt_idx)
  );

  // named events for the checker
  logic fire, last_seg, last_req;
  assign fire     = req_valid && req_ready;
  assign last_seg = (seg_q == seglen_q);
  assign last_req = last_seg && !nxt_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      elem_q   <= '0;
      seg_q    <= '0;
      base_q   <= '0;
      stride_q <= '0;
      idx_q    <= 1'b0;
      pen_q    <= 1'b0;
      pinv_q   <= 1'b0;
      seglen_q <= '0;
      vl_q     <= '0;
      pmask_q  <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          base_q   <= base_addr;
          stride_q <= stride_in;
          idx_q    <= offs_vec;
          pen_q    <= pred_en;
          pinv_q   <= pred_inv;
          seglen_q <= seg_len;
          vl_q     <= vl;
          pmask_q  <= pred_mask;
          rd_q     <= rd_base;
          seg_q    <= '0;
          if (nxt_found) begin
            busy_q <= 1'b1;
            elem_q <= nxt_idx;
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (fire) begin
        if (!last_seg) begin
          seg_q <= seg_q + SEGW'(1);
        end else if (nxt_found) begin
          elem_q <= nxt_idx;
          seg_q  <= '0;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  vsl_addr_calc #(.AW(AW), .MAXVL(MAXVL), .SEGW(SEGW)) u_addr (
    .base(base_q), .stride(stride_q), .seglen(seglen_q), .elem(elem_q),
    .seg(seg_q), .indexed(idx_q), .idx_off(idx_rd_data), .addr(req_addr)
  );

  assign req_valid  = busy_q;
  assign req_reg    = rd_q + REGW'(seg_q);
  assign req_elem   = elem_q;
  assign idx_rd_sel = elem_q;
  assign done       = done_q;
endmodule

// File: rtl/vsl_agen_chk.sv
module vsl_agen_chk #(
  parameter int AW    = 32,
  parameter int MAXVL = 16,
  parameter int REGW  = 5,
  localparam int VLW = $clog2(MAXVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic [REGW-1:0]  req_reg,
  input logic [VLW-1:0]   req_elem,
  input logic             done,
  input logic             fire,
  input logic             last_seg,
  input logic             last_req,
  input logic             pen_q,
  input logic             pinv_q,
  input logic [MAXVL-1:0] pmask_q,
  input logic [VLW:0]     vl_q,
  input logic [REGW-1:0]  rd_q,
  input logic [AW-1:0]    base_q
);
  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
    $stable(req_reg) && $stable(req_elem));

  // R6
  pred_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pen_q |-> (pmask_q[req_elem] ^ pinv_q));

  // R6
  elem_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_elem} < vl_q));

  // R5
  seg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last_seg |=> req_valid && req_elem == $past(req_elem) &&
    req_reg == $past(req_reg) + REGW'(1));

  // R5
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_seg && !last_req |=> req_valid &&
    req_elem > $past(req_elem) && req_reg == rd_q);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_req |=> done && !req_valid);

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && start |=> $stable(base_q) && $stable(vl_q) && $stable(pmask_q));
endmodule

bind vsl_seg_load_agen vsl_agen_chk #(.AW(AW), .MAXVL(MAXVL), .REGW(REGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_reg(req_reg),
  .req_elem(req_elem), .done(done), .fire(fire), .last_seg(last_seg),
  .last_req(last_req), .pen_q(pen_q), .pinv_q(pinv_q), .pmask_q(pmask_q),
  .vl_q(vl_q), .rd_q(rd_q), .base_q(base_q)
);

// File: tb/vsl_seg_load_agen_bench.sv
module vsl_seg_load_agen_bench;
  localparam int AW = 32, MAXVL = 16, SEGW = 3, REGW = 5, VLW = 4;
  localparam int MAXREQ = MAXVL * 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0, elem_size = '0, stride_val = '0;
  logic const_stride = 1'b0, offs_vec = 1'b0;
  logic [VLW-1:0] idx_rd_sel;
  logic [AW-1:0] idx_rd_data;
  logic [SEGW-1:0] seg_len = '0;
  logic [VLW:0] vl = '0;
  logic pred_en = 1'b0, pred_inv = 1'b0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic [REGW-1:0] rd_base = '0;
  logic req_valid, req_ready = 1'b0, done;
  logic [AW-1:0] req_addr;
  logic [REGW-1:0] req_reg;
  logic [VLW-1:0] req_elem;

  logic [AW-1:0] idx_mem [MAXVL];
  assign idx_rd_data = idx_mem[idx_rd_sel];

  always #5 clk = ~clk;

  vsl_seg_load_agen u_vsl_seg_load_agen (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [AW-1:0]   e_addr [MAXREQ];
  logic [REGW-1:0] e_reg  [MAXREQ];
  logic [VLW-1:0]  e_elem [MAXREQ];
  int n_exp;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit elem_on(input int i);
    if (i >= int'(vl)) return 1'b0;
    if (!pred_en) return 1'b1;
    return pred_mask[i] ^ pred_inv;
  endfunction

  function automatic logic [AW-1:0] want_addr(input int i, input int j);
    logic [AW-1:0] s, off;
    s   = const_stride ? stride_val : elem_size;
    off = offs_vec ? idx_mem[i] : AW'(i * (int'(seg_len) + 1)) * s;
    return base_addr + off + AW'(j) * s;
  endfunction

  task automatic build_exp();
    n_exp = 0;
    for (int i = 0; i < MAXVL; i++) begin
      if (elem_on(i)) begin
        for (int j = 0; j <= int'(seg_len); j++) begin
          e_addr[n_exp] = want_addr(i, j);
          e_reg[n_exp]  = rd_base + REGW'(j);
          e_elem[n_exp] = VLW'(i);
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input int ready_pct, input int poke);
    int got = 0, cyc = 0;
    bit hold_pend = 1'b0;
    logic [AW-1:0] h_addr;
    logic [REGW-1:0] h_reg;
    logic [VLW-1:0] h_elem;
    build_exp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      req_ready = (($urandom % 100) < ready_pct);
      if (cyc == poke) begin
        start = 1'b1;
        base_addr = base_addr ^ 32'h0001_0000;
      end else begin
        start = 1'b0;
      end
      #1;
      if (hold_pend) begin
        chk(req_valid && req_addr == h_addr && req_reg == h_reg && req_elem == h_elem,
            "R8", "stalled request changed", {req_addr, 27'(req_elem)}, {h_addr, 27'(h_elem)});
      end
      if (got == n_exp) begin
        chk(done && !req_valid, tag, "done after last accept (R9)",
            {done, req_valid}, 2'b10);
        start = 1'b0;
        @(negedge clk); #1;
        chk(!done, "R9", "done longer than one cycle", done, 0);
        break;
      end
      if (done) begin
        chk(1'b0, tag, "early done (R9), requests seen", got, n_exp);
        break;
      end
      if (req_valid && req_ready) begin
        chk(req_addr == e_addr[got] && req_reg == e_reg[got] && req_elem == e_elem[got],
            tag, $sformatf("request %0d addr/reg/elem", got),
            {req_addr, 11'(req_reg), 16'(req_elem)},
            {e_addr[got], 11'(e_reg[got]), 16'(e_elem[got])});
        if (offs_vec)
          chk(idx_rd_sel == e_elem[got], "R4", "index read select", idx_rd_sel, e_elem[got]);
        got++;
        hold_pend = 1'b0;
      end else if (req_valid) begin
        hold_pend = 1'b1;
        h_addr = req_addr; h_reg = req_reg; h_elem = req_elem;
      end else begin
        hold_pend = 1'b0;
      end
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, tag, "case hung, requests seen", got, n_exp);
        break;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    start = 1'b0;
  endtask

  task automatic setcfg(input logic [AW-1:0] b, input logic [AW-1:0] es,
                        input logic [AW-1:0] sv, input bit cs, input bit ov,
                        input int sl, input int v, input bit pe, input bit pi,
                        input logic [MAXVL-1:0] pm, input int rd);
    base_addr = b; elem_size = es; stride_val = sv; const_stride = cs;
    offs_vec = ov; seg_len = SEGW'(sl); vl = (VLW+1)'(v); pred_en = pe;
    pred_inv = pi; pred_mask = pm; rd_base = REGW'(rd);
  endtask

  initial begin
    void'($urandom(32'd20611));
    for (int k = 0; k < MAXVL; k++) idx_mem[k] = AW'(k * 40 + 3);
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!req_valid && !done, "R1", "outputs in reset", {req_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!req_valid && !done, "R1", "outputs idle after reset", {req_valid, done}, 0);

    // R2 R7 unit stride, no predication
    setcfg(32'h1000, 4, 32'h99, 0, 0, 0, 4, 0, 0, '0, 8);
    run_case("R2", 100, -1);
    setcfg(32'h2000, 8, 32'h99, 0, 0, 2, 3, 0, 1, '0, 1);
    run_case("R7", 60, -1);
    // R3 R6 constant stride with predicate, plain and inverted
    setcfg(32'h8000, 2, 32'h30, 1, 0, 1, 10, 1, 0, 16'b0000_0010_0110_1001, 4);
    run_case("R3", 70, -1);
    setcfg(32'h8000, 2, 32'h30, 1, 0, 1, 10, 1, 1, 16'b0000_0010_0110_1001, 4);
    run_case("R6", 50, -1);
    // R4 indexed
    setcfg(32'h4000, 4, 32'h10, 0, 1, 1, 6, 1, 0, 16'h00_2D, 2);
    run_case("R4", 80, -1);
    setcfg(32'h4000, 4, 32'h10, 1, 1, 0, 5, 0, 0, '0, 2);
    run_case("R4", 100, -1);
    // R10 wrap near top
    setcfg(32'hFFFF_FFF0, 4, 32'h0, 0, 0, 3, 3, 0, 0, '0, 0);
    run_case("R10", 100, -1);
    // R9 empty runs
    setcfg(32'h100, 4, 0, 0, 0, 2, 0, 0, 0, '0, 0);
    run_case("R9", 100, -1);
    setcfg(32'h100, 4, 0, 0, 0, 2, 8, 1, 0, 16'hFF00, 0);
    run_case("R6", 100, -1);
    // R5 full length, largest segment, register wrap
    setcfg(32'h0, 1, 0, 0, 0, 7, 16, 0, 0, '0, 30);
    run_case("R5", 90, -1);
    // R11 start while busy
    setcfg(32'h5000, 4, 0, 0, 0, 1, 6, 0, 0, '0, 3);
    run_case("R11", 100, 2);

    // random mix
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < MAXVL; k++) idx_mem[k] = $urandom;
      setcfg($urandom, AW'(1 << ($urandom % 4)),
             ($urandom % 2) ? $urandom : AW'($urandom % 64),
             $urandom % 2, $urandom % 2, $urandom % 8, $urandom % 17,
             $urandom % 2, $urandom % 2, MAXVL'($urandom), $urandom % 32);
      run_case("R5", 30 + $urandom % 71, -1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule